// File: doc/BRIEF.md
# Dual-Rail Constructive Fixpoint Evaluator

The block solves a small cyclic Boolean network, X = I and not Y, Y = J and not X, with constructive three-valued logic. It does not guess a Boolean answer. Each of X and Y is held on a pair of rails. One rail is set once the value 1 has been proven from the inputs. The other rail is set once the value 0 has been proven. Every clock cycle the block applies the rail equations once to all signals. It keeps doing so until a cycle produces no change.

A caller presents I and J and pulses `start` for one cycle. The block captures the inputs on that edge and clears both signals to unknown. It then iterates. It raises `done` on the first cycle in which the rails did not move. At that point `constructive` reports whether each signal settled to exactly one rail. An input pair whose loop cannot be resolved by any proof is flagged as non-constructive. The result is held until the next start pulse.

Top module: `cyc_eval`

## Requirements
- R1: After reset, `x_rail` and `y_rail` read 2'b00, and `done`, `constructive` and `rail_err` are 0.
- R2: Each rail pair puts the one-rail at bit 1 and the zero-rail at bit 0. The code 2'b10 means logic 1, 2'b01 means logic 0 and 2'b00 means unknown.
- R3: A cycle with `start` high captures `in_i` and `in_j`, clears both rail pairs to 2'b00 and clears `done`. Changes on `in_i` or `in_j` after that edge have no effect on the result. A new `start` during an evaluation abandons it and begins again from the new inputs.
- R4: While iterating, every clock edge sets X.one = I & Y.zero, X.zero = ~I | Y.one, Y.one = J & X.zero and Y.zero = ~J | X.one, all from the rails held before that edge. A rail once set is never cleared during an evaluation.
- R5: `done` rises after the first edge whose update leaves both rail pairs unchanged. Counted in edges after the start edge, this is 3 for I=0,J=1, 3 for I=1,J=0, 2 for I=J=0 and 1 for I=J=1.
- R6: I=0,J=1 ends with X=2'b01 and Y=2'b10. I=1,J=0 ends with X=2'b10 and Y=2'b01. I=J=0 ends with X=Y=2'b01. All three set `constructive`.
- R7: I=J=1 ends with both rail pairs at 2'b00 and `constructive` at 0.
- R8: Once `done` is high, it and both rail pairs and `constructive` stay constant until the next `start`.
- R9: `rail_err` is 1 exactly when either rail pair holds 2'b11. A legal evaluation never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin an evaluation |
| in_i | input | 1 | Input I |
| in_j | input | 1 | Input J |
| x_rail | output | 2 | X rails {one, zero} |
| y_rail | output | 2 | Y rails {one, zero} |
| done | output | 1 | Fixpoint reached, result held |
| constructive | output | 1 | Every signal resolved to one rail |
| rail_err | output | 1 | A rail pair reads 2'b11 |

## Verification
The bench covers all four input pairs. It checks the final rails and the constructive flag, and it also checks the exact edge on which `done` rises. An update order that is sequential instead of simultaneous, or a convergence test that compares the wrong values, would show up as a shifted latency. In the I=J=1 case the loop must stay unknown. A design that seeded the loop with a guessed value would report X or Y resolved there and call it constructive. A restart in the middle of an evaluation and input changes after the start edge are both driven at the ports. A design that failed to clear the rails, or that read the inputs live, would return a mixed result. The bench also checks that the result stays fixed over idle cycles after `done`.

// File: rtl/cyc_eval.sv
module cyc_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_i,
  input  logic       in_j,
  output logic [1:0] x_rail,
  output logic [1:0] y_rail,
  output logic       done,
  output logic       constructive,
  output logic       rail_err
);

  logic       i_q, j_q, busy;
  logic [1:0] i_r, j_r, x_nx, y_nx;
  logic       settled;

  assign i_r = {i_q, ~i_q};
  assign j_r = {j_q, ~j_q};

  // R4: one simultaneous step of the rail equations
  assign x_nx = {i_r[1] & y_rail[0], i_r[0] | y_rail[1]};
  assign y_nx = {j_r[1] & x_rail[0], j_r[0] | x_rail[1]};

  assign settled  = (x_nx == x_rail) && (y_nx == y_rail);
  assign rail_err = (&x_rail) | (&y_rail);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_q <= 1'b0; j_q <= 1'b0; busy <= 1'b0;
      x_rail <= 2'b00; y_rail <= 2'b00;
      done <= 1'b0; constructive <= 1'b0;
    end else if (start) begin
      i_q <= in_i; j_q <= in_j; busy <= 1'b1;
      x_rail <= 2'b00; y_rail <= 2'b00;
      done <= 1'b0; constructive <= 1'b0;
    end else if (busy) begin
      x_rail <= x_nx;
      y_rail <= y_nx;
      if (settled) begin
        busy <= 1'b0;
        done <= 1'b1;
        constructive <= (^x_rail) & (^y_rail);
      end
    end
  end

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (x_rail == 2'b00 && y_rail == 2'b00 && !done));

  a_r4_rails_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (((x_rail & $past(x_rail)) == $past(x_rail)) &&
                          ((y_rail & $past(y_rail)) == $past(y_rail))));

  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(x_rail) && $stable(y_rail) && $stable(constructive)));

  a_r7_both_high_unresolved: assert property (@(posedge clk) disable iff (!rst_n)
    (done && i_q && j_q) |-> (!constructive && x_rail == 2'b00 && y_rail == 2'b00));

  a_r9_no_illegal_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_err);

  a_r6_constructive_resolved: assert property (@(posedge clk) disable iff (!rst_n)
    (done && constructive) |-> (x_rail != 2'b00 && y_rail != 2'b00));

endmodule

// File: tb/cyc_eval_bench.sv
module cyc_eval_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_i = 1'b0, in_j = 1'b0;
  logic [1:0] x_rail, y_rail;
  logic done, constructive, rail_err;

  always #4 clk = ~clk;

  cyc_eval u_cyc_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .in_i(in_i), .in_j(in_j),
    .x_rail(x_rail), .y_rail(y_rail), .done(done),
    .constructive(constructive), .rail_err(rail_err)
  );

  typedef struct {
    logic [1:0] x;
    logic [1:0] y;
    logic       c;
    int         lat;
  } exp_t;

  exp_t sb[$];
  int tests = 0, fails = 0;
  int cyc = 0;
  logic prev_done = 1'b0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (start) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // monitor: pops one expectation per rising done
  always @(negedge clk) begin
    if (rst_n && done && !prev_done) begin
      if (sb.size() == 0) check("R5 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check("R6/R7 x_rail", {30'd0, x_rail}, {30'd0, e.x});
        check("R6/R7 y_rail", {30'd0, y_rail}, {30'd0, e.y});
        check("R6/R7 constructive", {31'd0, constructive}, {31'd0, e.c});
        check("R5 latency", cyc, e.lat);
        check("R9 rail_err", {31'd0, rail_err}, 0);
      end
    end
    prev_done <= done;
  end

  function automatic exp_t model(input logic i, input logic j);
    exp_t e;
    case ({i, j})
      2'b01: begin e.x = 2'b01; e.y = 2'b10; e.c = 1'b1; e.lat = 3; end
      2'b10: begin e.x = 2'b10; e.y = 2'b01; e.c = 1'b1; e.lat = 3; end
      2'b00: begin e.x = 2'b01; e.y = 2'b01; e.c = 1'b1; e.lat = 2; end
      default: begin e.x = 2'b00; e.y = 2'b00; e.c = 1'b0; e.lat = 1; end
    endcase
    return e;
  endfunction

  task automatic kick(input logic i, input logic j, input bool_push);
    @(negedge clk);
    start = 1'b1; in_i = i; in_j = j;
    if (bool_push) sb.push_back(model(i, j));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20 && sb.size() != 0; k++) @(negedge clk);
    check("R5 done reached", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 x_rail", {30'd0, x_rail}, 0);
    check("R1 y_rail", {30'd0, y_rail}, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 constructive", {31'd0, constructive}, 0);
    check("R1 rail_err", {31'd0, rail_err}, 0);
    rst_n = 1'b1;

    // R2 R4 R5 R6 R7: every input pair
    kick(1'b0, 1'b1, 1'b1); wait_idle();
    kick(1'b1, 1'b0, 1'b1); wait_idle();
    kick(1'b0, 1'b0, 1'b1); wait_idle();
    kick(1'b1, 1'b1, 1'b1); wait_idle();

    // R8 hold after done
    kick(1'b1, 1'b0, 1'b1); wait_idle();
    repeat (5) @(negedge clk);
    check("R8 done held", {31'd0, done}, 1);
    check("R8 x held", {30'd0, x_rail}, 2'b10);
    check("R8 y held", {30'd0, y_rail}, 2'b01);
    check("R8 constructive held", {31'd0, constructive}, 1);

    // R3 inputs ignored after start edge
    @(negedge clk);
    start = 1'b1; in_i = 1'b0; in_j = 1'b1;
    sb.push_back(model(1'b0, 1'b1));
    @(negedge clk);
    start = 1'b0; in_i = 1'b1; in_j = 1'b0;
    check("R3 rails cleared x", {30'd0, x_rail}, 0);
    check("R3 rails cleared y", {30'd0, y_rail}, 0);
    check("R3 done cleared", {31'd0, done}, 0);
    wait_idle();

    // R3 restart mid-evaluation
    kick(1'b1, 1'b0, 1'b0);
    kick(1'b1, 1'b1, 1'b1);
    wait_idle();
    kick(1'b0, 1'b0, 1'b0);
    kick(1'b0, 1'b1, 1'b1);
    wait_idle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule